// File: doc/BRIEF.md
# E-Manchester Nibble Codec

This block puts bytes on a single-wire bus that has an active and a passive state, and reads them back from the same wire. Each byte is split into two groups of four bits, most significant bit first. The first three bits of a group are sent as plain level (NRZ) bits. The fourth bit is an L-Manchester bit, whose mid-bit edge is always present. Because the line is wired so that the active state wins, a logic 0 (active) beats a logic 1 (passive) in every bit position.

The encoder takes one byte at a time through a valid/ready handshake. It frames the byte as follows:
- a start bit that holds the line active for one bit time,
- the eight coded data bits,
- one passive guard bit.

Every byte therefore takes the same time on the wire. The decoder synchronises the line, waits for the falling edge of a start bit, and then times the half-bit windows from that edge. It keeps a modulo-4 group position so that it knows which bit is the Manchester bit. A Manchester edge looks just like a boundary edge, so that position is the only way to tell the two apart. The decoder raises an error pulse and drops the byte in two cases: an edge arrives outside a legal window, or a Manchester bit lacks its mid-bit edge.

Top module: `emn_codec`

## Requirements
- R1: After reset, tx_ready_o is 1, bus_drive_o is 0 (passive), and rx_valid_o and rx_err_o are 0.
- R2: An accepted byte is framed as follows. One start bit is active for BIT_TICKS cycles. Eight data bits follow, MSB first, each BIT_TICKS cycles long. One passive guard bit ends the frame. tx_ready_o is low for exactly 10*BIT_TICKS cycles per byte. bus_drive_o is 0 whenever the encoder is idle.
- R3: Group positions 0, 1 and 2 are NRZ bits; these are data bits 7, 6, 5 and 3, 2, 1. Each is driven active (bus_drive_o=1) for the whole bit when the bit is 0, and passive when it is 1.
- R4: Group position 3 is the Manchester bit; these are data bits 4 and 0. It is driven at level equal to its value for the first half and at the inverted level for the second half. So 0 gives active then passive, and 1 gives passive then active.
- R5: An edge appears at the boundary in front of a Manchester bit exactly when the preceding NRZ bit differs from the Manchester value.
- R6: A well-formed frame on bus_sense_i yields one rx_valid_o pulse of one cycle, with rx_data_o equal to the byte sent. rx_data_o changes only with that pulse.
- R7: The decoder raises a one-cycle rx_err_o pulse and delivers no byte for that frame in either of these cases:
  - an edge falls more than EDGE_WIN cycles away from a half-bit boundary;
  - an edge falls at the middle of an NRZ bit.
- R8: A Manchester bit whose two halves carry the same level raises rx_err_o, and no byte is delivered for that frame.
- R9: After an error, the decoder hunts for a new start edge and decodes the next clean frame correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | tx_data_i holds a byte |
| tx_ready_o | output | 1 | Encoder idle; byte taken when valid and ready |
| bus_drive_o | output | 1 | 1 pulls the bus to its active state |
| bus_sense_i | input | 1 | Bus level, 1 = passive, 0 = active |
| rx_data_o | output | 8 | Last decoded byte |
| rx_valid_o | output | 1 | One-cycle pulse with a new byte |
| rx_err_o | output | 1 | One-cycle pulse on an invalid edge or a missing Manchester edge |

## Verification
The bench builds the codec with BIT_TICKS=8 and EDGE_WIN=1. A half-bit is therefore four cycles, and a complete frame lasts 80 cycles. At that size, all 256 byte values can be sent back to back through a loopback. Every half-bit level is compared against levels computed from the data bits, and every decoded byte is compared against the byte sent. The one-cycle edge window makes single-cycle injected pulses and forced levels land exactly in an illegal window or inside a Manchester half. This exercises both error paths and the recovery that follows them.

// File: rtl/emn_pkg.sv
`timescale 1ns/1ps
package emn_pkg;
  localparam int BYTE_W       = 8;
  localparam int GRP_LEN      = 4;
  localparam int BIT_IDX_W    = $clog2(BYTE_W);
  localparam int FRAME_BITS   = BYTE_W + 2;          // start + data + guard
  localparam int FRAME_HALVES = 2 * FRAME_BITS;
  localparam int HIX_W        = $clog2(FRAME_HALVES + 1);
  localparam int DATA_FIRST   = 2;                   // first data half index
  localparam int DATA_LAST    = DATA_FIRST + 2*BYTE_W - 1;

  // data bit index (0 = MSB sent first) carries the Manchester symbol
  function automatic logic is_manch(input logic [BIT_IDX_W-1:0] idx);
    return (32'(idx) % GRP_LEN) == (GRP_LEN - 1);
  endfunction
endpackage

// File: rtl/emn_tx.sv
`timescale 1ns/1ps
module emn_tx import emn_pkg::*; #(
  parameter int HALF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              drive_o
);
  localparam int CNT_W = $clog2(HALF);

  logic                 busy_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [HIX_W-1:0]     hix_q;
  logic [BYTE_W-1:0]    byte_q;
  logic [BIT_IDX_W-1:0] bidx;
  logic                 lvl;

  wire last_tick = (cnt_q == CNT_W'(HALF-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hix_q  <= '0;
      byte_q <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q <= 1'b1;
        byte_q <= data_i;
        cnt_q  <= '0;
        hix_q  <= '0;
      end
    end else if (last_tick) begin
      cnt_q <= '0;
      if (hix_q == HIX_W'(FRAME_HALVES-1)) busy_q <= 1'b0;
      else                                 hix_q  <= hix_q + HIX_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign bidx = BIT_IDX_W'((hix_q - HIX_W'(DATA_FIRST)) >> 1);

  // line level, 1 = passive
  always_comb begin
    lvl = 1'b1;
    if (busy_q) begin
      if (hix_q < HIX_W'(DATA_FIRST)) begin
        lvl = 1'b0;
      end else if (hix_q <= HIX_W'(DATA_LAST)) begin
        lvl = byte_q[BIT_IDX_W'(BYTE_W-1) - bidx];
        if (is_manch(bidx) && hix_q[0]) lvl = ~lvl;
      end
    end
  end

  assign drive_o = ~lvl;
  assign ready_o = ~busy_q;
endmodule

// File: rtl/emn_sync.sv
`timescale 1ns/1ps
module emn_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign edge_o = s2_q ^ prev_q;
endmodule

// File: rtl/emn_rx.sv
`timescale 1ns/1ps
module emn_rx import emn_pkg::*; #(
  parameter int HALF     = 4,
  parameter int EDGE_WIN = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_i,
  input  logic              edge_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(HALF);

  logic                 run_q, fh_q, sh_q, valid_q, err_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [HIX_W-1:0]     hix_q;
  logic [BYTE_W-1:0]    shreg_q, data_q;
  logic [BIT_IDX_W-1:0] bidx;
  logic                 edge_ok;

  // odd boundaries are mid-bit: legal only inside a Manchester bit
  function automatic logic legal_bnd(input logic [HIX_W-1:0] b);
    logic [HIX_W-1:0] k;
    if (!b[0]) return 1'b1;
    if (b < HIX_W'(DATA_FIRST+1)) return 1'b0;
    k = (b - HIX_W'(DATA_FIRST+1)) >> 1;
    return is_manch(BIT_IDX_W'(k));
  endfunction

  wire last_tick = (cnt_q == CNT_W'(HALF-1));
  wire mid_tick  = (cnt_q == CNT_W'(HALF/2));

  assign bidx    = BIT_IDX_W'((hix_q - HIX_W'(DATA_FIRST)) >> 1);
  assign edge_ok = ((cnt_q <  CNT_W'(EDGE_WIN))      && legal_bnd(hix_q)) ||
                   ((cnt_q >= CNT_W'(HALF-EDGE_WIN)) && legal_bnd(hix_q + HIX_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      hix_q   <= '0;
      fh_q    <= 1'b1;
      sh_q    <= 1'b1;
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (!run_q) begin
        if (edge_i && !lvl_i) begin       // start bit leading edge
          run_q <= 1'b1;
          cnt_q <= CNT_W'(1);
          hix_q <= '0;
        end
      end else if (edge_i && !edge_ok) begin
        err_q <= 1'b1;
        run_q <= 1'b0;
      end else begin
        if (mid_tick) begin
          if (hix_q[0]) sh_q <= lvl_i;
          else          fh_q <= lvl_i;
        end
        if (last_tick) begin
          cnt_q <= '0;
          hix_q <= hix_q + HIX_W'(1);
          if (hix_q[0] && hix_q > HIX_W'(DATA_FIRST)) begin
            if (is_manch(bidx) && (fh_q == sh_q)) begin
              err_q <= 1'b1;
              run_q <= 1'b0;
            end else begin
              shreg_q <= {shreg_q[BYTE_W-2:0], fh_q};
              if (hix_q == HIX_W'(DATA_LAST)) begin
                data_q  <= {shreg_q[BYTE_W-2:0], fh_q};
                valid_q <= 1'b1;
                run_q   <= 1'b0;
              end
            end
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/emn_codec.sv
`timescale 1ns/1ps
module emn_codec #(
  parameter int BIT_TICKS = 4800,
  parameter int EDGE_WIN  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic       bus_drive_o,
  input  logic       bus_sense_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       rx_err_o
);
  localparam int HALF = BIT_TICKS / 2;

  logic lvl, edg;

  emn_tx #(.HALF(HALF)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .drive_o (bus_drive_o)
  );

  emn_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (bus_sense_i),
    .lvl_o  (lvl),
    .edge_o (edg)
  );

  emn_rx #(.HALF(HALF), .EDGE_WIN(EDGE_WIN)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .edge_i  (edg),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .err_o   (rx_err_o)
  );
endmodule

// File: rtl/emn_codec_chk.sv
`timescale 1ns/1ps
module emn_codec_chk #(
  parameter int BIT_TICKS = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       bus_drive_o,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_err_o
);
  localparam int FRAME_CYC = emn_pkg::FRAME_HALVES * (BIT_TICKS / 2);

  int busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_cnt <= 0;
    else if (tx_ready_o) busy_cnt <= 0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  // R2
  idle_passive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !bus_drive_o);
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> (busy_cnt == FRAME_CYC));
  // R6
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> rx_valid_o);
  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_err_o));
endmodule

bind emn_codec emn_codec_chk #(.BIT_TICKS(BIT_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .bus_drive_o (bus_drive_o),
  .rx_data_o   (rx_data_o),
  .rx_valid_o  (rx_valid_o),
  .rx_err_o    (rx_err_o)
);

// File: tb/emn_codec_bench.sv
`timescale 1ns/1ps
module emn_codec_bench;
  localparam int BT = 8;
  localparam int H  = BT / 2;
  localparam int FR = 20 * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, bus_drive, rx_valid, rx_err;
  logic [7:0] rx_data;
  logic       inj_en = 1'b0, inj_val = 1'b1;
  wire        bus_sense = inj_en ? inj_val : ~bus_drive;

  int n_tests = 0, n_fail = 0, rx_cnt = 0, err_cnt = 0;
  logic [7:0] rx_last = '0;

  always #10 clk = ~clk;

  emn_codec #(.BIT_TICKS(BT), .EDGE_WIN(1)) u_emn_codec (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .bus_drive_o(bus_drive), .bus_sense_i(bus_sense),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_err_o(rx_err)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
    if (rx_err) err_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_lvl(input logic [7:0] b, input int h);
    int k; logic v;
    if (h < 2) return 1'b0;
    if (h >= 18) return 1'b1;
    k = (h - 2) / 2;
    v = b[7-k];
    if ((k % 4 == 3) && (h % 2 == 1)) v = ~v;
    return v;
  endfunction

  // sends one byte; injection window in negedge index n after acceptance
  task automatic run_frame(input logic [7:0] b, input int is, input int il,
                           input logic iv, input bit clean);
    int r0, e0; logic [19:0] smp; bit busy_ok; bit ok_nrz, ok_man, ok_bnd, ok_frm;
    while (!tx_ready) @(negedge clk);
    r0 = rx_cnt; e0 = err_cnt; busy_ok = 1;
    tx_data = b; tx_valid = 1'b1;
    @(posedge clk);
    for (int n = 0; n < FR; n++) begin
      @(negedge clk);
      if (n == 0) tx_valid = 1'b0;
      inj_val = iv;
      inj_en  = (n >= is) && (n < is + il);
      if (n % H == H/2) smp[n/H] = ~bus_drive;
      if (tx_ready) busy_ok = 0;
    end
    @(negedge clk);
    inj_en = 1'b0;
    ok_frm = busy_ok && tx_ready && (smp[1:0] == 2'b00) && (smp[19:18] == 2'b11);
    // R2 framing and constant byte time
    check(ok_frm, "R2 frame", int'(smp), int'(b));
    ok_nrz = 1; ok_man = 1; ok_bnd = 1;
    for (int k = 0; k < 8; k++) begin
      if (k % 4 == 3) begin
        if (smp[2+2*k] != exp_lvl(b, 2+2*k) || smp[3+2*k] != exp_lvl(b, 3+2*k)) ok_man = 0;
        if ((smp[1+2*k] != smp[2+2*k]) != (b[7-(k-1)] != b[7-k])) ok_bnd = 0;
      end else begin
        if (smp[2+2*k] != b[7-k] || smp[3+2*k] != b[7-k]) ok_nrz = 0;
      end
    end
    check(ok_nrz, "R3 nrz levels", int'(smp), int'(b));
    check(ok_man, "R4 manchester halves", int'(smp), int'(b));
    check(ok_bnd, "R5 boundary edge", int'(smp), int'(b));
    if (clean) begin
      // R6 loopback decode
      check(rx_cnt == r0 + 1 && rx_last == b && err_cnt == e0, "R6 decode",
            int'(rx_last), int'(b));
    end else begin
      repeat (2*BT) @(negedge clk);
    end
  endtask

  initial begin
    int r0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_ready == 1'b1 && bus_drive == 1'b0, "R1 tx reset", {tx_ready, bus_drive}, 2'b10);
    check(rx_valid == 1'b0 && rx_err == 1'b0, "R1 rx reset", {rx_valid, rx_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_ready == 1'b1 && bus_drive == 1'b0 && rx_valid == 1'b0, "R1 after release",
          {tx_ready, bus_drive, rx_valid}, 3'b100);

    for (int v = 0; v < 256; v++) run_frame(8'(v), -1, 0, 1'b1, 1'b1);

    // R7 short active pulse inside an NRZ half-bit
    r0 = rx_cnt; e0 = err_cnt;
    run_frame(8'hFF, 2*H+1, 2, 1'b0, 1'b0);
    check(err_cnt > e0 && rx_cnt == r0, "R7 glitch in window", err_cnt - e0, 1);

    // R7 edge at the middle of an NRZ bit
    r0 = rx_cnt; e0 = err_cnt;
    run_frame(8'h00, 3*H, H, 1'b1, 1'b0);
    check(err_cnt > e0 && rx_cnt == r0, "R7 nrz mid edge", err_cnt - e0, 1);

    // R9 recovery
    run_frame(8'hA5, -1, 0, 1'b1, 1'b1);

    // R8 Manchester bit 3 second half forced active: no mid edge
    r0 = rx_cnt; e0 = err_cnt;
    run_frame(8'h00, 9*H, H, 1'b0, 1'b0);
    check(err_cnt == e0 + 1 && rx_cnt == r0, "R8 missing mid edge", err_cnt - e0, 1);

    // R8 second Manchester bit (data bit 0) forced passive on a 1
    r0 = rx_cnt; e0 = err_cnt;
    run_frame(8'h11, 17*H, H, 1'b1, 1'b0);
    check(err_cnt > e0 && rx_cnt == r0, "R8 missing mid edge late", err_cnt - e0, 1);

    // R9 recovery after Manchester error
    run_frame(8'h3C, -1, 0, 1'b1, 1'b1);
    run_frame(8'hC3, -1, 0, 1'b1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule